// File: doc/BRIEF.md
# Register File with Boot-Time Preload

This block is a byte-wide, single-port general purpose register file with a small sequencer that loads it after reset. Every reset clears the storage. Once reset is released, the sequencer takes the write enable, address and data lines. It makes one write per clock, filling the low locations with an incrementing byte pattern that starts at a base value.

When the preload is finished, the sequencer raises a done flag and gives up the address and write lines. From then on, an external selector (for example a bank of switches) chooses which location to read. An external write port can then also update the contents. Read data is registered: the output shows the location addressed at the previous rising edge.

Top module: `regfile_boot_loader`

## Requirements
- R1: The storage has 32 locations of 8 bits each, selected by a 5-bit address. `rd_data` shows, after each rising edge, the contents (before any write at that edge) of the location addressed at that edge.
- R2: While `rst_n` is low, `rd_data` is 0x00 and `init_done` is 0, and every location is cleared to 0x00.
- R3: After reset release, the sequencer makes one write per clock. At step k (k = 0..30) it writes address k with the value 0x1A + k, computed modulo 256. So address 0 holds 0x1A and address 30 holds 0x38.
- R4: `init_done` is low for the first 30 rising edges after reset release. It is high after the 31st, and it then stays high until reset.
- R5: Location 31 is never written by the sequencer and reads 0x00 after the preload.
- R6: While `init_done` is low, `ext_addr`, `ext_we` and `ext_wdata` have no effect on the stored contents.
- R7: While `init_done` is high, `ext_addr` selects the location read. When `ext_we` is high at a rising edge, `ext_wdata` is written to `ext_addr`.
- R8: Asserting `rst_n` low at any time, including in the middle of the preload, clears `init_done` and restarts the preload from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_we | input | 1 | External write enable, honoured only after the preload |
| ext_addr | input | 5 | External location select |
| ext_wdata | input | 8 | External write data |
| rd_data | output | 8 | Registered read data |
| init_done | output | 1 | High once the preload has finished |

## Verification
Some behaviours are checked by assertions on every cycle. Once the done flag is high it stays high. While the preload runs, the step counter advances by exactly one per clock and never passes the last step. After the last step the done flag rises on the next edge. A write lands at the address it was presented with. Other behaviours can only be shown by the bench's scenarios: the actual preload values, how long the preload takes counted from reset release, the reading of location 31, the blocking of external writes and addresses during the preload, and a restart after a reset in mid-preload.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
    localparam int          RFB_DEPTH = 32;
    localparam int          RFB_WIDTH = 8;
    localparam int          RFB_COUNT = 31;
    localparam logic [7:0]  RFB_BASE  = 8'h1A;
endpackage

// File: rtl/rfb_init_seq.sv
module rfb_init_seq #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    parameter int COUNT = 31,
    parameter logic [WIDTH-1:0] BASE = 8'h1A,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             seq_we,
    output logic [AW-1:0]    seq_addr,
    output logic [WIDTH-1:0] seq_data,
    output logic             init_done
);
    localparam logic [AW-1:0] LAST = AW'(COUNT - 1);

    typedef struct packed {
        logic [AW-1:0] step;
        logic          done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            if (st_q.step == LAST) begin
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_we    = !st_q.done;
    assign seq_addr  = st_q.step;
    assign seq_data  = BASE + WIDTH'(st_q.step);
    assign init_done = st_q.done;

    // R4: once finished, stays finished until reset
    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done);

    // R4: the last step is followed by done
    p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.done && st_q.step == LAST) |=> st_q.done);

    // R3: one step per clock while active
    p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.done && st_q.step != LAST) |=> (st_q.step == $past(st_q.step) + 1'b1));

    // R3: the step never runs past the last preloaded address
    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step <= LAST);
endmodule

// File: rtl/rfb_port_mux.sv
module rfb_port_mux #(
    parameter int WIDTH = 8,
    parameter int AW    = 5
) (
    input  logic             init_done,
    input  logic             seq_we,
    input  logic [AW-1:0]    seq_addr,
    input  logic [WIDTH-1:0] seq_data,
    input  logic             ext_we,
    input  logic [AW-1:0]    ext_addr,
    input  logic [WIDTH-1:0] ext_wdata,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [WIDTH-1:0] mem_wdata
);
    always_comb begin
        if (init_done) begin
            mem_we    = ext_we;
            mem_addr  = ext_addr;
            mem_wdata = ext_wdata;
        end else begin
            mem_we    = seq_we;
            mem_addr  = seq_addr;
            mem_wdata = seq_data;
        end
    end
endmodule

// File: rtl/rfb_storage.sv
module rfb_storage #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [WIDTH-1:0]            rd;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.rd = s_q.mem[addr];
        if (we) begin
            s_d.mem[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rd;

    // R7: a presented write is held at its address afterwards
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (s_q.mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/regfile_boot_loader.sv
module regfile_boot_loader
    import rfb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_we,
    input  logic [4:0] ext_addr,
    input  logic [7:0] ext_wdata,
    output logic [7:0] rd_data,
    output logic       init_done
);
    localparam int AW = $clog2(RFB_DEPTH);

    logic             seq_we;
    logic [AW-1:0]    seq_addr;
    logic [RFB_WIDTH-1:0] seq_data;
    logic             mem_we;
    logic [AW-1:0]    mem_addr;
    logic [RFB_WIDTH-1:0] mem_wdata;

    rfb_init_seq #(
        .DEPTH(RFB_DEPTH), .WIDTH(RFB_WIDTH), .COUNT(RFB_COUNT), .BASE(RFB_BASE)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .seq_we(seq_we), .seq_addr(seq_addr),
        .seq_data(seq_data), .init_done(init_done)
    );

    rfb_port_mux #(.WIDTH(RFB_WIDTH), .AW(AW)) i_mux (
        .init_done(init_done), .seq_we(seq_we), .seq_addr(seq_addr), .seq_data(seq_data),
        .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    rfb_storage #(.DEPTH(RFB_DEPTH), .WIDTH(RFB_WIDTH)) i_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rd_data(rd_data)
    );

    // R6: while preloading, the storage sees only the sequencer's address
    p_ext_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (mem_addr == seq_addr && mem_we));
endmodule

// File: tb/test_regfile_boot_loader.sv
module test_regfile_boot_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_we = 1'b0;
    logic [4:0] ext_addr = '0;
    logic [7:0] ext_wdata = '0;
    logic [7:0] rd_data;
    logic       init_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    regfile_boot_loader i_regfile_boot_loader (
        .clk(clk), .rst_n(rst_n), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .rd_data(rd_data), .init_done(init_done)
    );

    // {address, expected byte}
    localparam logic [12:0] VEC [8] = '{
        {5'd0,  8'h1A}, {5'd1,  8'h1B}, {5'd5,  8'h1F}, {5'd15, 8'h29},
        {5'd29, 8'h37}, {5'd30, 8'h38}, {5'd31, 8'h00}, {5'd17, 8'h2B}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [4:0] a, output logic [7:0] v);
        ext_addr = a;
        @(posedge clk);
        @(negedge clk);
        v = rd_data;
    endtask

    // Release reset, drive external write noise during preload, return edge count.
    task automatic run_preload(output int edges);
        ext_we = 1'b1; ext_addr = 5'd5; ext_wdata = 8'hFF;   // R6 noise
        rst_n = 1'b1;
        edges = 0;
        while (!init_done && edges < 100) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges == 30) check("R4 low at edge 30", init_done, 0);
        end
        ext_we = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] v;
        repeat (2) @(negedge clk);
        check("R2 rd_data in reset", rd_data, 0);
        check("R2 init_done in reset", init_done, 0);

        run_preload(n);
        check("R4 preload edges", n, 31);
        check("R4 done high", init_done, 1);

        for (int i = 0; i < 8; i++) begin
            read_at(VEC[i][12:8], v);
            check("R3/R5/R6 vector", v, VEC[i][7:0]);
        end
        for (int a = 0; a < 32; a++) begin
            read_at(5'(a), v);
            check("R1/R3/R5 sweep", v, (a < 31) ? ((8'h1A + a) & 8'hFF) : 0);
        end
        check("R4 done stays high", init_done, 1);

        // R7: external write after preload
        ext_addr = 5'd31; ext_wdata = 8'h5A; ext_we = 1'b1;
        @(posedge clk); @(negedge clk);
        ext_we = 1'b0;
        read_at(5'd31, v);
        check("R7 ext write", v, 8'h5A);
        read_at(5'd2, v);
        check("R7 ext select", v, 8'h1C);

        // R1: read shows old contents when write and read coincide
        ext_addr = 5'd3; ext_wdata = 8'hC3; ext_we = 1'b1;
        @(posedge clk); @(negedge clk);
        ext_we = 1'b0;
        check("R1 read before write", rd_data, 8'h1D);
        read_at(5'd3, v);
        check("R1 new value", v, 8'hC3);

        // R8: reset in mid-preload
        rst_n = 1'b0; #1;
        check("R8 done cleared", init_done, 0);
        check("R2 rd cleared", rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R8 still preloading", init_done, 0);
        rst_n = 1'b0;
        @(negedge clk);
        run_preload(n);
        check("R8 restart edges", n, 31);
        read_at(5'd0, v);
        check("R8 addr0 reloaded", v, 8'h1A);
        read_at(5'd31, v);
        check("R8/R5 loc31 cleared", v, 0);
        read_at(5'd3, v);
        check("R8 addr3 reloaded", v, 8'h1D);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule